// File: doc/BRIEF.md
# Thread Interrupt Presenter Context

This block holds the interrupt management state of one hardware thread for operating-system exceptions. A routing engine sends notifications that each carry a 3-bit priority. The block records each one as a bit in an 8-bit pending set. It works out the most favored pending level, where a numerically lower value is more favored. It compares that level with the thread's current priority and drives a single interrupt line toward the core.

Software reaches the context through a small register bus. Two address bits above the page offset select one of four views: the full physical view, the hypervisor view, the operating-system view and the user view. Inside a page, the thread can read the status, current-priority, pending and top-priority registers, and can write the current priority. A special acknowledge read returns the priority being taken and, in the same step, raises the current priority to that level and retires the pending bit. The top priority level is kept for escalation and is never accepted from a notification.

Top module: `irq_presenter_ctx`

## Requirements
- R1: A notification with priority 0 to 6 sets bit p of the pending register. Reading offset 2 returns the pending set with bit i standing for priority i.
- R2: A notification with priority 7 is dropped and leaves the pending register unchanged.
- R3: Reading offset 3 returns the lowest-numbered pending priority. When nothing is pending it returns 0xFF.
- R4: `irq_out` and bit 7 of the status register (offset 0, all other bits zero) are high exactly when the top pending priority is numerically less than the current priority, compared as unsigned 8-bit values. They follow any change of either value from the cycle after the clock edge that makes the change. A current priority of 0xFF lets every pending level through.
- R5: An acknowledge read (offset 4) made while the exception is signalled does three things. It returns the top pending priority, writes that value into the current priority and clears its pending bit. `irq_out` falls in the next cycle unless a more favored level is still pending.
- R6: An acknowledge read made while the exception is not signalled returns 0xFF and changes no state.
- R7: Address bits [PAGE_SHIFT+1:PAGE_SHIFT] select the view: 00 physical, 01 hypervisor, 10 operating system, 11 user. Register offsets are the low PAGE_SHIFT bits. Read data and `rd_valid` appear in the cycle after the request. Unused offsets read 0.
- R8: A write to offset 1 loads the current priority from the physical, hypervisor and operating-system views, and takes effect in the next cycle. The same write from the user view is ignored.
- R9: An acknowledge read from the user view returns 0xFF and changes no state, even while the exception is signalled.
- R10: After reset the pending set is empty, the current priority is 0x00 (everything masked), and `irq_out` is low.
- R11: When a notification arrives in the same cycle as an acknowledge of the same priority, the pending bit for that priority remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ntf_valid | input | 1 | Notification strobe from the routing engine |
| ntf_prio | input | 3 | Priority of the notification |
| req_valid | input | 1 | Register bus request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | PAGE_SHIFT+2 | View select bits and register offset |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 8 | Read data |
| irq_out | output | 1 | Operating-system exception line to the core |

## Verification
The bench builds the block with its default page shift of 4, so each view page is 16 bytes and the whole window is 64 bytes. In this window, each register offset and all four view select patterns can be reached with short address values. The 8-level priority width lets the bench target the reserved top level directly. It also covers the strict-less-than boundary, where the current priority equals the pending one, and an acknowledge that collides with a same-priority notification.

// File: rtl/ipc_pkg.sv
package ipc_pkg;

    localparam int PRIO_W  = 3;
    localparam int NPRIO   = 1 << PRIO_W;
    localparam int DATA_W  = 8;
    localparam int RSVD_PRIO = NPRIO - 1;

    localparam logic [DATA_W-1:0] PRIO_NONE = '1;

    localparam int OFS_STATUS = 0;
    localparam int OFS_CUR    = 1;
    localparam int OFS_PEND   = 2;
    localparam int OFS_TOP    = 3;
    localparam int OFS_ACK    = 4;

    typedef enum logic [1:0] {
        VIEW_PHYS = 2'b00,
        VIEW_HYP  = 2'b01,
        VIEW_OS   = 2'b10,
        VIEW_USER = 2'b11
    } view_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_CUR,
        SEL_PEND,
        SEL_TOP,
        SEL_ACK
    } sel_e;

    typedef struct packed {
        logic              rd;
        logic              wr;
        view_e             view;
        sel_e              sel;
        logic [DATA_W-1:0] wdata;
    } bus_op_t;

    function automatic logic [DATA_W-1:0] most_favored(input logic [NPRIO-1:0] pend);
        logic [DATA_W-1:0] r;
        r = PRIO_NONE;
        for (int i = NPRIO - 1; i >= 0; i--) begin
            if (pend[i]) r = DATA_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/ipc_decode.sv
module ipc_decode
    import ipc_pkg::*;
#(
    parameter int PAGE_SHIFT = 4,
    localparam int ADDR_W = PAGE_SHIFT + 2
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output bus_op_t           op
);
    logic [PAGE_SHIFT-1:0] ofs;

    always_comb begin
        ofs      = req_addr[PAGE_SHIFT-1:0];
        op.rd    = req_valid && !req_write;
        op.wr    = req_valid && req_write;
        op.view  = view_e'(req_addr[ADDR_W-1:PAGE_SHIFT]);
        op.wdata = req_wdata;
        if (ofs == PAGE_SHIFT'(OFS_STATUS))      op.sel = SEL_STATUS;
        else if (ofs == PAGE_SHIFT'(OFS_CUR))    op.sel = SEL_CUR;
        else if (ofs == PAGE_SHIFT'(OFS_PEND))   op.sel = SEL_PEND;
        else if (ofs == PAGE_SHIFT'(OFS_TOP))    op.sel = SEL_TOP;
        else if (ofs == PAGE_SHIFT'(OFS_ACK))    op.sel = SEL_ACK;
        else                                     op.sel = SEL_NONE;
    end
endmodule

// File: rtl/ipc_pending.sv
module ipc_pending
    import ipc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              set_valid,
    input  logic [PRIO_W-1:0] set_prio,
    input  logic              clr_valid,
    input  logic [PRIO_W-1:0] clr_prio,
    output logic [NPRIO-1:0]  pend,
    output logic [DATA_W-1:0] top_prio
);
    for (genvar i = 0; i < NPRIO; i++) begin : g_lvl
        if (i == RSVD_PRIO) begin : g_rsvd
            assign pend[i] = 1'b0;
        end else begin : g_bit
            logic bit_q;
            always_ff @(posedge clk) begin
                if (rst)
                    bit_q <= 1'b0;
                else if (set_valid && set_prio == PRIO_W'(i))
                    bit_q <= 1'b1;
                else if (clr_valid && clr_prio == PRIO_W'(i))
                    bit_q <= 1'b0;
            end
            assign pend[i] = bit_q;
        end
    end

    assign top_prio = most_favored(pend);
endmodule

// File: rtl/ipc_cur.sv
module ipc_cur
    import ipc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_val,
    input  logic              ack_en,
    input  logic [DATA_W-1:0] ack_val,
    output logic [DATA_W-1:0] cppr
);
    always_ff @(posedge clk) begin
        if (rst)
            cppr <= '0;
        else if (ack_en)
            cppr <= ack_val;
        else if (wr_en)
            cppr <= wr_val;
    end
endmodule

// File: rtl/irq_presenter_ctx.sv
module irq_presenter_ctx
    import ipc_pkg::*;
#(
    parameter int PAGE_SHIFT = 4,
    localparam int ADDR_W = PAGE_SHIFT + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ntf_valid,
    input  logic [PRIO_W-1:0] ntf_prio,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_out
);
    bus_op_t           op;
    logic [NPRIO-1:0]  pend;
    logic [DATA_W-1:0] top_prio;
    logic [DATA_W-1:0] cppr;
    logic              exc;
    logic              priv_view;
    logic              ack_fire;
    logic              cur_wr;
    logic              ntf_ok;
    logic [DATA_W-1:0] rd_mux;
    logic              rd_valid_q;
    logic [DATA_W-1:0] rd_data_q;

    ipc_decode #(.PAGE_SHIFT(PAGE_SHIFT)) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .op        (op)
    );

    assign ntf_ok    = ntf_valid && (ntf_prio != PRIO_W'(RSVD_PRIO));
    assign exc       = top_prio < cppr;
    assign priv_view = op.view != VIEW_USER;
    assign ack_fire  = op.rd && op.sel == SEL_ACK && priv_view && exc;
    assign cur_wr    = op.wr && op.sel == SEL_CUR && priv_view;

    ipc_pending u_pend (
        .clk       (clk),
        .rst       (rst),
        .set_valid (ntf_ok),
        .set_prio  (ntf_prio),
        .clr_valid (ack_fire),
        .clr_prio  (top_prio[PRIO_W-1:0]),
        .pend      (pend),
        .top_prio  (top_prio)
    );

    ipc_cur u_cur (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cur_wr),
        .wr_val  (op.wdata),
        .ack_en  (ack_fire),
        .ack_val (top_prio),
        .cppr    (cppr)
    );

    always_comb begin
        unique case (op.sel)
            SEL_STATUS: rd_mux = {exc, {(DATA_W-1){1'b0}}};
            SEL_CUR:    rd_mux = cppr;
            SEL_PEND:   rd_mux = DATA_W'(pend);
            SEL_TOP:    rd_mux = top_prio;
            SEL_ACK:    rd_mux = ack_fire ? top_prio : PRIO_NONE;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= op.rd;
            if (op.rd) rd_data_q <= rd_mux;
        end
    end

    assign rd_valid = rd_valid_q;
    assign rd_data  = rd_data_q;
    assign irq_out  = exc;
endmodule

// File: rtl/ipc_chk.sv
module ipc_chk
    import ipc_pkg::*;
#(
    parameter int PAGE_SHIFT = 4,
    localparam int ADDR_W = PAGE_SHIFT + 2
) (
    input logic              clk,
    input logic              rst,
    input logic              ntf_valid,
    input logic [PRIO_W-1:0] ntf_prio,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [NPRIO-1:0]  pend,
    input logic [DATA_W-1:0] top_prio,
    input logic [DATA_W-1:0] cppr,
    input logic              ack_fire,
    input logic              irq_out
);
    logic user_cur_wr;
    assign user_cur_wr = req_valid && req_write
                      && req_addr[ADDR_W-1:PAGE_SHIFT] == 2'b11
                      && req_addr[PAGE_SHIFT-1:0] == PAGE_SHIFT'(OFS_CUR);

    // R1
    set_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (ntf_valid && ntf_prio != PRIO_W'(RSVD_PRIO)) |=> pend[$past(ntf_prio)]);

    // R2
    rsvd_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (ntf_valid && ntf_prio == PRIO_W'(RSVD_PRIO)) |=> !pend[RSVD_PRIO]);

    // R4
    irq_pending_chk: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (top_prio != PRIO_NONE));

    // R5
    ack_cur_chk: assert property (@(posedge clk) disable iff (rst)
        ack_fire |=> cppr == $past(top_prio));

    // R5
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_fire && !ntf_valid) |=> !pend[$past(top_prio[PRIO_W-1:0])]);

    // R5
    ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_fire && !ntf_valid) |=> !irq_out);

    // R8
    user_cur_chk: assert property (@(posedge clk) disable iff (rst)
        user_cur_wr |=> $stable(cppr));
endmodule

bind irq_presenter_ctx ipc_chk #(.PAGE_SHIFT(PAGE_SHIFT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ntf_valid (ntf_valid),
    .ntf_prio  (ntf_prio),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .pend      (pend),
    .top_prio  (top_prio),
    .cppr      (cppr),
    .ack_fire  (ack_fire),
    .irq_out   (irq_out)
);

// File: tb/irq_presenter_ctx_test.sv
`timescale 1ns/1ps
module irq_presenter_ctx_test;
    localparam int PS = 4;
    localparam int AW = PS + 2;
    localparam logic [1:0] V_PHYS = 2'b00, V_HYP = 2'b01, V_OS = 2'b10, V_USER = 2'b11;
    localparam int O_STAT = 0, O_CUR = 1, O_PEND = 2, O_TOP = 3, O_ACK = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ntf_valid = 1'b0;
    logic [2:0]    ntf_prio = '0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_wdata = '0;
    logic          rd_valid;
    logic [7:0]    rd_data;
    logic          irq_out;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    irq_presenter_ctx #(.PAGE_SHIFT(PS)) uut (
        .clk, .rst, .ntf_valid, .ntf_prio, .req_valid, .req_write,
        .req_addr, .req_wdata, .rd_valid, .rd_data, .irq_out
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic notify(input logic [2:0] p);
        @(negedge clk);
        ntf_valid = 1'b1; ntf_prio = p;
        @(negedge clk);
        ntf_valid = 1'b0;
    endtask

    task automatic bwr(input logic [1:0] v, input int o, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = {v, PS'(o)}; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic brd(input logic [1:0] v, input int o, output logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = {v, PS'(o)};
        @(negedge clk);
        req_valid = 1'b0;
        chk("R7 rd_valid", {7'b0, rd_valid}, 8'h01);
        d = rd_data;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        chk("R10 irq after reset", {7'b0, irq_out}, 8'h00);
        brd(V_PHYS, O_PEND, d); chk("R10 pending empty", d, 8'h00);
        brd(V_PHYS, O_TOP, d);  chk("R3 top none", d, 8'hFF);
        brd(V_PHYS, O_CUR, d);  chk("R10 cur prio", d, 8'h00);
        brd(V_PHYS, 9, d);      chk("R7 unused offset", d, 8'h00);
    endtask

    task automatic t_masked_then_open;
        logic [7:0] d;
        notify(3'd5);
        chk("R4 masked irq", {7'b0, irq_out}, 8'h00);
        brd(V_OS, O_PEND, d); chk("R1 pending bit5", d, 8'h20);
        brd(V_OS, O_TOP, d);  chk("R3 top 5", d, 8'h05);
        brd(V_OS, O_STAT, d); chk("R4 status clear", d, 8'h00);
        bwr(V_OS, O_CUR, 8'hFF);
        chk("R4 R8 irq after open", {7'b0, irq_out}, 8'h01);
        brd(V_OS, O_STAT, d); chk("R4 status set", d, 8'h80);
    endtask

    task automatic t_ack;
        logic [7:0] d;
        notify(3'd2);
        brd(V_OS, O_TOP, d); chk("R3 top 2", d, 8'h02);
        brd(V_OS, O_ACK, d); chk("R5 ack value", d, 8'h02);
        chk("R5 irq falls", {7'b0, irq_out}, 8'h00);
        brd(V_OS, O_CUR, d);  chk("R5 cur from ack", d, 8'h02);
        brd(V_OS, O_PEND, d); chk("R5 bit cleared", d, 8'h20);
    endtask

    task automatic t_boundary;
        bwr(V_OS, O_CUR, 8'h06);
        chk("R4 cur 6 passes 5", {7'b0, irq_out}, 8'h01);
        bwr(V_OS, O_CUR, 8'h05);
        chk("R4 cur 5 blocks 5", {7'b0, irq_out}, 8'h00);
    endtask

    task automatic t_user_write;
        logic [7:0] d;
        bwr(V_USER, O_CUR, 8'hFF);
        chk("R8 user write irq", {7'b0, irq_out}, 8'h00);
        brd(V_USER, O_CUR, d); chk("R8 user write ignored", d, 8'h05);
    endtask

    task automatic t_idle_ack;
        logic [7:0] d;
        brd(V_OS, O_ACK, d);  chk("R6 idle ack value", d, 8'hFF);
        brd(V_OS, O_PEND, d); chk("R6 pending kept", d, 8'h20);
        brd(V_OS, O_CUR, d);  chk("R6 cur kept", d, 8'h05);
    endtask

    task automatic t_reserved;
        logic [7:0] d;
        notify(3'd7);
        brd(V_OS, O_PEND, d); chk("R2 prio7 dropped", d, 8'h20);
        brd(V_OS, O_TOP, d);  chk("R2 top unchanged", d, 8'h05);
    endtask

    task automatic t_views;
        logic [7:0] d;
        bwr(V_HYP, O_CUR, 8'hFF);
        chk("R8 hyp write opens", {7'b0, irq_out}, 8'h01);
        brd(V_USER, O_ACK, d); chk("R9 user ack value", d, 8'hFF);
        chk("R9 irq kept", {7'b0, irq_out}, 8'h01);
        brd(V_HYP, O_ACK, d);  chk("R5 hyp ack value", d, 8'h05);
        brd(V_HYP, O_TOP, d);  chk("R3 top none after ack", d, 8'hFF);
        chk("R5 irq low empty", {7'b0, irq_out}, 8'h00);
        bwr(V_PHYS, O_CUR, 8'h04);
        brd(V_PHYS, O_CUR, d); chk("R8 phys write", d, 8'h04);
    endtask

    task automatic t_multi;
        logic [7:0] d;
        bwr(V_OS, O_CUR, 8'hFF);
        notify(3'd6); notify(3'd1); notify(3'd4);
        brd(V_OS, O_PEND, d); chk("R1 three bits", d, 8'h52);
        brd(V_OS, O_TOP, d);  chk("R3 most favored", d, 8'h01);
        brd(V_OS, O_ACK, d);  chk("R5 ack 1", d, 8'h01);
        chk("R4 cur1 blocks 4", {7'b0, irq_out}, 8'h00);
        bwr(V_OS, O_CUR, 8'hFF);
        brd(V_OS, O_ACK, d);  chk("R5 ack 4", d, 8'h04);
        bwr(V_OS, O_CUR, 8'hFF);
        brd(V_OS, O_ACK, d);  chk("R5 ack 6", d, 8'h06);
    endtask

    task automatic t_collide;
        logic [7:0] d;
        bwr(V_OS, O_CUR, 8'hFF);
        notify(3'd3);
        @(negedge clk);
        ntf_valid = 1'b1; ntf_prio = 3'd3;
        req_valid = 1'b1; req_write = 1'b0; req_addr = {V_OS, PS'(O_ACK)};
        @(negedge clk);
        ntf_valid = 1'b0; req_valid = 1'b0;
        chk("R11 ack value", rd_data, 8'h03);
        brd(V_OS, O_PEND, d); chk("R11 bit kept", d, 8'h08);
        chk("R11 irq blocked", {7'b0, irq_out}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_masked_then_open();
        t_ack();
        t_boundary();
        t_user_write();
        t_idle_ack();
        t_reserved();
        t_views();
        t_multi();
        t_collide();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule